// File: doc/BRIEF.md
# Four-Way Instruction Translation Buffer with Pairwise LRU

This block is a small fully associative translation buffer that sits in front of an instruction fetch unit. Each of its four ways holds a virtual page number, an address-space identifier, a comparison mask derived from the page size, a physical page number and a set of attribute flags. A lookup compares the presented virtual page number against every valid way. It can optionally require the address-space identifier to match, and a way marked shared matches any identifier. The result is a single hit, a multiple hit, or a miss.

On a miss the block raises a refill request towards a larger unified translation buffer and stalls. When the unified buffer answers with an entry, that entry is written into the way picked by a 6-bit pairwise recency code. The lookup then completes as a hit on that way. A miss or multiple hit reported by the unified buffer is handed back unchanged and nothing is written. Fetches issued in user mode that hit a way without user access permission complete with a protection status instead of a hit.

Top module: `itlb_four_way`

## Requirements
- R1: After synchronous reset, `lk_ready` is 1, `rsp_valid` and `rf_req` are 0, every way is invalid, and the recency code is 0, so the first refill lands in way 3.
- R2: A way matches when its flag bit 8 (valid) is set and the lookup page number equals the stored one under the size mask given by flag bits {7,4}: 00 = 1 KiB (all 22 page bits compared), 01 = 4 KiB (low 2 ignored), 10 = 64 KiB (low 6 ignored), 11 = 1 MiB (low 10 ignored).
- R3: With `lk_match_asid` = 1 a way also needs its stored identifier equal to `lk_asid` unless its flag bit 1 (shared) is set; with `lk_match_asid` = 0 the identifier is ignored.
- R4: A lookup accepted while `lk_ready` is 1 that matches exactly one way yields `rsp_valid` one cycle later with `rsp_status` = 0 (hit), `rsp_way` = that way, `rsp_refill` = 0 and `rsp_flags` = the stored flags.
- R5: A lookup matching two or more ways yields `rsp_status` = 2 (multi-hit) one cycle later and leaves the recency code unchanged.
- R6: A lookup matching no way raises `rf_req` one cycle later, with no response. `rf_vpn`, `rf_asid` and `rf_match_asid` carry the lookup's values and stay stable until `rf_ack`, and `lk_ready` stays 0 meanwhile.
- R7: When `rf_ack` arrives with `rf_status` = 0, the supplied entry is written into the victim way with its flags reduced to the bits in 0x1DA. One cycle later the response shows `rsp_refill` = 1, `rsp_way` = the victim way and the reduced flags.
- R8: When `rf_ack` arrives with `rf_status` = 2 the response is multi-hit (2). Any other nonzero value gives miss (1). Neither writes a way.
- R9: The victim comes from the recency code L, and the first rule that applies wins: way 0 if L[5], L[4] and L[3] are all 1; way 1 if {L[5],L[2],L[1]} = 011; way 2 if {L[4],L[2],L[0]} = 001; otherwise way 3.
- R10: Using a way (a single hit or a refill into it) updates L as follows. Way 0 clears L[5:3]. Way 1 keeps L & 0x19 and sets L[5]. Way 2 keeps L & 0x3E and sets L[4] and L[2]. Way 3 sets L[3], L[1] and L[0].
- R11: With `lk_user` = 1, a hit or refill on a way whose flag bit 6 (user access) is 0 responds with `rsp_status` = 3 (protection) on that way, and the recency code is still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Block can accept a lookup |
| lk_vpn | input | 22 | Virtual page number (address bits 31:10) |
| lk_asid | input | 8 | Current address-space identifier |
| lk_match_asid | input | 1 | Require identifier match |
| lk_user | input | 1 | Fetch issued in user mode |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 0 hit, 1 miss, 2 multi-hit, 3 protection |
| rsp_way | output | 2 | Way that hit or was refilled |
| rsp_refill | output | 1 | Response follows a refill |
| rsp_flags | output | 9 | Flags of the selected way |
| rsp_ppn | output | 19 | Physical page number of the selected way |
| rf_req | output | 1 | Refill request to the unified buffer |
| rf_vpn | output | 22 | Page number being refilled |
| rf_asid | output | 8 | Identifier for the unified search |
| rf_match_asid | output | 1 | Identifier mode for the unified search |
| rf_ack | input | 1 | Unified buffer answer strobe |
| rf_status | input | 2 | 0 hit, 2 multi-hit, other values miss |
| rf_ent_vpn | input | 22 | Returned entry page number |
| rf_ent_asid | input | 8 | Returned entry identifier |
| rf_ent_ppn | input | 19 | Returned entry physical page |
| rf_ent_flags | input | 9 | Returned entry flags |

## Verification
The properties assume that `rf_ack` is asserted only while `rf_req` is high, for a single cycle. They also assume that `lk_valid` is acted upon only in cycles where `lk_ready` is 1. The bench's refill responder answers two cycles after it sees a request and drops the acknowledge on the next cycle. Its lookup driver waits for `lk_ready` and for the previous response before it issues the next lookup. The entry set is built up through refills so that overlapping ways, and so the multi-hit case, arise only from the identifier-ignoring mode.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int VPN_W   = 22;
  localparam int ASID_W  = 8;
  localparam int PPN_W   = 19;
  localparam int FLAG_W  = 9;
  localparam int WAYS    = 4;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int LRU_W   = 6;

  localparam logic [FLAG_W-1:0] KEEP_FLAGS = 9'h1DA;
  localparam int FB_VALID  = 8;
  localparam int FB_SZ_HI  = 7;
  localparam int FB_USER   = 6;
  localparam int FB_SZ_LO  = 4;
  localparam int FB_SHARED = 1;

  typedef enum logic [1:0] {
    ST_HIT   = 2'd0,
    ST_MISS  = 2'd1,
    ST_MULTI = 2'd2,
    ST_PROT  = 2'd3
  } rsp_status_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [FLAG_W-1:0] flags;
  } tlb_ent_t;

  // Page-number bits that take part in the comparison for a size code.
  function automatic logic [VPN_W-1:0] vpn_keep(input logic [FLAG_W-1:0] f);
    logic [VPN_W-1:0] ones;
    ones = {VPN_W{1'b1}};
    case ({f[FB_SZ_HI], f[FB_SZ_LO]})
      2'b00:   return ones;
      2'b01:   return ones << 2;
      2'b10:   return ones << 6;
      default: return ones << 10;
    endcase
  endfunction

  function automatic logic [WAY_W-1:0] lru_pick(input logic [LRU_W-1:0] l);
    if (l[5] && l[4] && l[3])                 return 2'd0;
    else if ({l[5], l[2], l[1]} == 3'b011)    return 2'd1;
    else if ({l[4], l[2], l[0]} == 3'b001)    return 2'd2;
    else                                      return 2'd3;
  endfunction

  function automatic logic [LRU_W-1:0] lru_use(input logic [LRU_W-1:0] l,
                                               input logic [WAY_W-1:0] w);
    case (w)
      2'd0:    return {3'b000, l[2:0]};
      2'd1:    return (l & 6'h19) | 6'h20;
      2'd2:    return (l & 6'h3E) | 6'h14;
      default: return l | 6'h0B;
    endcase
  endfunction
endpackage

// File: rtl/itlb_entry_array.sv
module itlb_entry_array
  import itlb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [WAY_W-1:0]      wr_way,
  input  tlb_ent_t              wr_ent,
  input  logic [VPN_W-1:0]      cmp_vpn,
  input  logic [ASID_W-1:0]     cmp_asid,
  input  logic                  cmp_use_asid,
  output logic [WAYS-1:0]       hit_vec,
  output tlb_ent_t [WAYS-1:0]   way_ent
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tlb_ent_t         ent_q;
    logic [VPN_W-1:0] keep_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q  <= '0;
        keep_q <= '1;
      end else if (wr_en && wr_way == WAY_W'(g)) begin
        ent_q  <= wr_ent;
        keep_q <= vpn_keep(wr_ent.flags);
      end
    end

    assign hit_vec[g] = ent_q.flags[FB_VALID]
                     && (!cmp_use_asid || ent_q.flags[FB_SHARED] || ent_q.asid == cmp_asid)
                     && (((ent_q.vpn ^ cmp_vpn) & keep_q) == '0);
    assign way_ent[g] = ent_q;
  end
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru
  import itlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             use_en,
  input  logic [WAY_W-1:0] use_way,
  output logic [WAY_W-1:0] victim
);
  logic [LRU_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)         code_q <= '0;
    else if (use_en) code_q <= lru_use(code_q, use_way);
  end

  assign victim = lru_pick(code_q);
endmodule

// File: rtl/itlb_ctrl.sv
module itlb_ctrl
  import itlb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [ASID_W-1:0]   lk_asid,
  input  logic                lk_match_asid,
  input  logic                lk_user,
  input  logic [WAYS-1:0]     hit_vec,
  input  tlb_ent_t [WAYS-1:0] way_ent,
  input  logic [WAY_W-1:0]    victim,
  output logic                use_en,
  output logic [WAY_W-1:0]    use_way,
  output logic                wr_en,
  output tlb_ent_t            wr_ent,
  output logic                rsp_valid,
  output logic [1:0]          rsp_status,
  output logic [WAY_W-1:0]    rsp_way,
  output logic                rsp_refill,
  output logic [FLAG_W-1:0]   rsp_flags,
  output logic [PPN_W-1:0]    rsp_ppn,
  output logic                rf_req,
  output logic [VPN_W-1:0]    rf_vpn,
  output logic [ASID_W-1:0]   rf_asid,
  output logic                rf_match_asid,
  input  logic                rf_ack,
  input  logic [1:0]          rf_status,
  input  logic [VPN_W-1:0]    rf_ent_vpn,
  input  logic [ASID_W-1:0]   rf_ent_asid,
  input  logic [PPN_W-1:0]    rf_ent_ppn,
  input  logic [FLAG_W-1:0]   rf_ent_flags
);
  typedef enum logic {S_IDLE, S_WAIT} state_e;
  state_e state_q;
  logic   user_q;

  logic [WAY_W-1:0]    hit_idx;
  logic [WAY_W:0]      hit_cnt;
  tlb_ent_t            hit_ent;
  logic                accept, one_hit, many_hit, fill_ok;
  logic [FLAG_W-1:0]   fill_flags;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < WAYS; i++)
      if (hit_vec[i]) hit_idx = WAY_W'(i);
    hit_cnt = (WAY_W+1)'($countones(hit_vec));
    hit_ent = way_ent[hit_idx];
  end

  assign lk_ready   = (state_q == S_IDLE);
  assign accept     = lk_ready && lk_valid;
  assign one_hit    = accept && hit_cnt == 1;
  assign many_hit   = accept && hit_cnt > 1;
  assign fill_ok    = (state_q == S_WAIT) && rf_ack && rf_status == 2'd0;
  assign fill_flags = rf_ent_flags & KEEP_FLAGS;

  assign use_en  = one_hit || fill_ok;
  assign use_way = one_hit ? hit_idx : victim;
  assign wr_en   = fill_ok;
  assign wr_ent  = '{vpn: rf_ent_vpn, asid: rf_ent_asid, ppn: rf_ent_ppn, flags: fill_flags};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      user_q        <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_status    <= ST_HIT;
      rsp_way       <= '0;
      rsp_refill    <= 1'b0;
      rsp_flags     <= '0;
      rsp_ppn       <= '0;
      rf_req        <= 1'b0;
      rf_vpn        <= '0;
      rf_asid       <= '0;
      rf_match_asid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (one_hit) begin
            rsp_valid  <= 1'b1;
            rsp_status <= (lk_user && !hit_ent.flags[FB_USER]) ? ST_PROT : ST_HIT;
            rsp_way    <= hit_idx;
            rsp_refill <= 1'b0;
            rsp_flags  <= hit_ent.flags;
            rsp_ppn    <= hit_ent.ppn;
          end else if (many_hit) begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_MULTI;
            rsp_way    <= '0;
            rsp_refill <= 1'b0;
            rsp_flags  <= '0;
            rsp_ppn    <= '0;
          end else if (accept) begin
            state_q       <= S_WAIT;
            rf_req        <= 1'b1;
            rf_vpn        <= lk_vpn;
            rf_asid       <= lk_asid;
            rf_match_asid <= lk_match_asid;
            user_q        <= lk_user;
          end
        end
        default: begin
          if (rf_ack) begin
            state_q   <= S_IDLE;
            rf_req    <= 1'b0;
            rsp_valid <= 1'b1;
            if (fill_ok) begin
              rsp_status <= (user_q && !fill_flags[FB_USER]) ? ST_PROT : ST_HIT;
              rsp_way    <= victim;
              rsp_refill <= 1'b1;
              rsp_flags  <= fill_flags;
              rsp_ppn    <= rf_ent_ppn;
            end else begin
              rsp_status <= (rf_status == 2'd2) ? ST_MULTI : ST_MISS;
              rsp_way    <= '0;
              rsp_refill <= 1'b0;
              rsp_flags  <= '0;
              rsp_ppn    <= '0;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/itlb_four_way.sv
module itlb_four_way
  import itlb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [ASID_W-1:0]   lk_asid,
  input  logic                lk_match_asid,
  input  logic                lk_user,
  output logic                rsp_valid,
  output logic [1:0]          rsp_status,
  output logic [WAY_W-1:0]    rsp_way,
  output logic                rsp_refill,
  output logic [FLAG_W-1:0]   rsp_flags,
  output logic [PPN_W-1:0]    rsp_ppn,
  output logic                rf_req,
  output logic [VPN_W-1:0]    rf_vpn,
  output logic [ASID_W-1:0]   rf_asid,
  output logic                rf_match_asid,
  input  logic                rf_ack,
  input  logic [1:0]          rf_status,
  input  logic [VPN_W-1:0]    rf_ent_vpn,
  input  logic [ASID_W-1:0]   rf_ent_asid,
  input  logic [PPN_W-1:0]    rf_ent_ppn,
  input  logic [FLAG_W-1:0]   rf_ent_flags
);
  logic [WAYS-1:0]     hit_vec;
  tlb_ent_t [WAYS-1:0] way_ent;
  logic [WAY_W-1:0]    victim;
  logic                use_en;
  logic [WAY_W-1:0]    use_way;
  logic                wr_en;
  tlb_ent_t            wr_ent;

  itlb_entry_array u_array (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_way(victim), .wr_ent(wr_ent),
    .cmp_vpn(lk_vpn), .cmp_asid(lk_asid), .cmp_use_asid(lk_match_asid),
    .hit_vec(hit_vec), .way_ent(way_ent)
  );

  itlb_lru u_lru (
    .clk(clk), .rst(rst), .use_en(use_en), .use_way(use_way), .victim(victim)
  );

  itlb_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_match_asid(lk_match_asid), .lk_user(lk_user),
    .hit_vec(hit_vec), .way_ent(way_ent), .victim(victim),
    .use_en(use_en), .use_way(use_way), .wr_en(wr_en), .wr_ent(wr_ent),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_way(rsp_way),
    .rsp_refill(rsp_refill), .rsp_flags(rsp_flags), .rsp_ppn(rsp_ppn),
    .rf_req(rf_req), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_match_asid(rf_match_asid),
    .rf_ack(rf_ack), .rf_status(rf_status), .rf_ent_vpn(rf_ent_vpn),
    .rf_ent_asid(rf_ent_asid), .rf_ent_ppn(rf_ent_ppn), .rf_ent_flags(rf_ent_flags)
  );
endmodule

// File: rtl/itlb_four_way_chk.sv
module itlb_four_way_chk
  import itlb_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                lk_valid,
  input logic                lk_ready,
  input logic                rsp_valid,
  input logic [1:0]          rsp_status,
  input logic                rsp_refill,
  input logic [FLAG_W-1:0]   rsp_flags,
  input logic                rf_req,
  input logic [VPN_W-1:0]    rf_vpn,
  input logic [ASID_W-1:0]   rf_asid,
  input logic                rf_ack
);
  assert_req_held_R6: assert property (@(posedge clk) disable iff (rst)
    rf_req && !rf_ack |=> rf_req && $stable(rf_vpn) && $stable(rf_asid));

  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    rf_req |-> !lk_ready);

  assert_miss_silent_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_req) |-> !rsp_valid);

  assert_rsp_cause_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lk_valid && lk_ready) || $past(rf_req && rf_ack));

  assert_refill_ok_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_refill |-> (rsp_status == ST_HIT || rsp_status == ST_PROT)
                               && ((rsp_flags & ~KEEP_FLAGS) == '0));

  assert_prot_flag_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status == ST_PROT |-> !rsp_flags[FB_USER]);
endmodule

bind itlb_four_way itlb_four_way_chk u_chk (.*);

// File: tb/itlb_four_way_tb.sv
module itlb_four_way_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        lk_valid = 0, lk_ready, lk_match_asid = 0, lk_user = 0;
  logic [21:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic        rsp_valid, rsp_refill;
  logic [1:0]  rsp_status, rsp_way;
  logic [8:0]  rsp_flags;
  logic [18:0] rsp_ppn;
  logic        rf_req, rf_match_asid;
  logic [21:0] rf_vpn;
  logic [7:0]  rf_asid;
  logic        rf_ack = 0;
  logic [1:0]  rf_status = '0;
  logic [21:0] rf_ent_vpn = '0;
  logic [7:0]  rf_ent_asid = '0;
  logic [18:0] rf_ent_ppn = '0;
  logic [8:0]  rf_ent_flags = '0;

  itlb_four_way u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [1:0] st; logic [1:0] way; logic refill; logic [8:0] flags; string req; } exp_t;
  exp_t sb[$];

  logic [1:0]  ut_status;
  logic [21:0] ut_vpn;
  logic [7:0]  ut_asid;
  logic [8:0]  ut_flags;
  logic [21:0] x_vpn;
  logic [7:0]  x_asid;
  logic        x_mode;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_ut(input logic [1:0] s, input logic [31:0] va,
                        input logic [7:0] a, input logic [8:0] f);
    ut_status = s; ut_vpn = va[31:10]; ut_asid = a; ut_flags = f;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] a, input bit m, input bit u,
                        input logic [1:0] es, input logic [1:0] ew, input bit er,
                        input logic [8:0] ef, input string req);
    exp_t e;
    e.st = es; e.way = ew; e.refill = er; e.flags = ef; e.req = req;
    sb.push_back(e);
    x_vpn = va[31:10]; x_asid = a; x_mode = m;
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    lk_valid = 1; lk_vpn = va[31:10]; lk_asid = a; lk_match_asid = m; lk_user = u;
    @(negedge clk);
    lk_valid = 0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every response.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) chk(0, "R4", "unexpected response", 32'(rsp_status), 32'hx);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_status == e.st, e.req, "status", 32'(rsp_status), 32'(e.st));
        chk(rsp_refill == e.refill, e.req, "refill", 32'(rsp_refill), 32'(e.refill));
        if (e.st == 2'd0 || e.st == 2'd3) begin
          chk(rsp_way == e.way, e.req, "way", 32'(rsp_way), 32'(e.way));
          chk(rsp_flags == e.flags, e.req, "flags", 32'(rsp_flags), 32'(e.flags));
        end
      end
    end
  end

  // Unified-buffer model: answers two cycles after a request, checks the request (R6).
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (rf_ack) rf_ack = 0;
      else if (!rst && rf_req) begin
        wait_cnt++;
        chk(!lk_ready, "R6", "ready during refill", 32'(lk_ready), 32'h0);
        if (wait_cnt == 2) begin
          chk(rf_vpn == x_vpn, "R6", "rf_vpn", 32'(rf_vpn), 32'(x_vpn));
          chk(rf_asid == x_asid && rf_match_asid == x_mode, "R6", "rf_asid/mode",
              {23'd0, rf_match_asid, rf_asid}, {23'd0, x_mode, x_asid});
          rf_ack = 1; rf_status = ut_status; rf_ent_vpn = ut_vpn;
          rf_ent_asid = ut_asid; rf_ent_ppn = 19'h1234; rf_ent_flags = ut_flags;
          wait_cnt = 0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk(lk_ready == 1 && rsp_valid == 0 && rf_req == 0, "R1", "reset outputs",
        {29'd0, lk_ready, rsp_valid, rf_req}, 32'h4);
    // empty array misses; code 0 refills way 3; flags reduced by 0x1DA
    set_ut(0, 32'h0001_0000, 8'h05, 9'h1FF);
    lookup(32'h0001_0000, 8'h05, 1, 0, 2'd0, 2'd3, 1, 9'h1DA, "R1");
    // 1 MiB page covers a distant offset
    lookup(32'h000F_F000, 8'h05, 1, 0, 2'd0, 2'd3, 0, 9'h1DA, "R2");
    // code 0x0B selects way 2
    set_ut(0, 32'h0040_0000, 8'h05, 9'h140);
    lookup(32'h0040_0000, 8'h05, 1, 0, 2'd0, 2'd2, 1, 9'h140, "R9");
    // 1 KiB page does not cover the next page; unified miss and multi returned
    set_ut(1, 32'h0040_0400, 8'h05, 9'h140);
    lookup(32'h0040_0400, 8'h05, 1, 0, 2'd1, 2'd0, 0, 9'h000, "R8");
    set_ut(2, 32'h0040_0400, 8'h05, 9'h140);
    lookup(32'h0040_0400, 8'h05, 1, 0, 2'd2, 2'd0, 0, 9'h000, "R8");
    // identifier mismatch, then identifier ignored
    set_ut(1, 32'h0040_0000, 8'h07, 9'h140);
    lookup(32'h0040_0000, 8'h07, 1, 0, 2'd1, 2'd0, 0, 9'h000, "R3");
    lookup(32'h0040_0000, 8'h07, 0, 0, 2'd0, 2'd2, 0, 9'h140, "R3");
    // shared 4 KiB entry: code 0x1E selects way 1
    set_ut(0, 32'h2000_0000, 8'h09, 9'h152);
    lookup(32'h2000_0000, 8'h05, 1, 0, 2'd0, 2'd1, 1, 9'h152, "R10");
    lookup(32'h2000_0FFC, 8'h05, 1, 0, 2'd0, 2'd1, 0, 9'h152, "R3");
    // user fetch of supervisor-only page: code 0x38 selects way 0
    set_ut(0, 32'h3000_0000, 8'h05, 9'h100);
    lookup(32'h3000_0000, 8'h05, 1, 1, 2'd3, 2'd0, 1, 9'h100, "R11");
    lookup(32'h3000_0000, 8'h05, 1, 0, 2'd0, 2'd0, 0, 9'h100, "R4");
    lookup(32'h3000_0000, 8'h05, 1, 1, 2'd3, 2'd0, 0, 9'h100, "R11");
    // code 0 again: second identifier for same page goes to way 3
    set_ut(0, 32'h0040_0000, 8'h07, 9'h140);
    lookup(32'h0040_0000, 8'h07, 1, 0, 2'd0, 2'd3, 1, 9'h140, "R9");
    // ignoring identifiers, ways 2 and 3 both match
    lookup(32'h0040_0000, 8'h07, 0, 0, 2'd2, 2'd0, 0, 9'h000, "R5");
    // code still 0x0B after the multi-hit: refill goes to way 2
    set_ut(0, 32'h5000_0000, 8'h05, 9'h140);
    lookup(32'h5000_0000, 8'h05, 1, 0, 2'd0, 2'd2, 1, 9'h140, "R5");
    // hits on way 3 then way 1 move the code to 0x39, victim way 0
    lookup(32'h0040_0000, 8'h07, 0, 0, 2'd0, 2'd3, 0, 9'h140, "R10");
    lookup(32'h2000_0000, 8'h05, 1, 0, 2'd0, 2'd1, 0, 9'h152, "R10");
    set_ut(0, 32'h6000_0000, 8'h05, 9'h140);
    lookup(32'h6000_0000, 8'h05, 1, 0, 2'd0, 2'd0, 1, 9'h140, "R10");
    lookup(32'h6000_0000, 8'h05, 1, 0, 2'd0, 2'd0, 0, 9'h140, "R7");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule